// File: doc/BRIEF.md
# Alternating-Clock Serial Receiver

This block receives a packet from a remote device over a two-wire bus. The remote end sets the speed. Each wire takes turns carrying the clock and the data. Both wires are sampled on every system clock cycle. The recovered bits are packed into bytes and stored in an internal buffer.

Reception ends in one of four ways:
- the end-of-packet pattern is detected;
- the buffer fills;
- the bus goes quiet for longer than a programmable limit;
- software aborts.

Software arms the receiver and waits for a status flag. It then reads the stored bytes through a request/response read port.

Each bit cycle has two phases:
- **Phase 1:** line A falls and line B carries the data.
- **Phase 2:** line B falls and line A carries the data.

Phase 1 normally ends with B high while A is still low. If A returns high while B is still low, that is the end-of-packet (lead-out) pattern.

Read port rules:
- A read request is accepted in a cycle where `rd_req_valid` and `rd_req_ready` are both high.
- `rd_req_ready` is high whenever the receiver is not busy.
- The response comes exactly one cycle after acceptance, as `rd_rsp_valid` with `rd_rsp_data`.
- The response side has no back-pressure.

Top module: `acr_rx`

## Requirements
- R1: After reset, `busy`, `done_irq`, `overflow`, `timeout` and `byte_count` are all 0, and `rd_req_ready` is 1.
- R2: In phase 1, a falling edge on line A captures the level of line B as the next bit. Phase 1 ends when B is high, and phase 2 then follows. In phase 2, a falling edge on line B captures the level of line A. Phase 2 ends when A is high, and phase 1 then follows.
- R3: Bits are packed most significant bit first. Each group of 8 bits is stored at buffer address `byte_count`, which then increments, so byte k of the packet is at address k.
- R4: A final group of fewer than 8 bits is discarded and never counted.
- R5: At the end of phase 1, if A is high while B is still low, the receiver stops. It then raises `done_irq` and drops `busy`.
- R6: At the end of phase 2, if the buffer already holds DEPTH (default 64) bytes, the receiver halts and raises `overflow`. No further byte is stored, so a longer packet keeps only its first DEPTH bytes.
- R7: While busy, if `timeout_cycles` cycles pass with no edge on either line, the receiver stops and raises `timeout`.
- R8: `abort` while busy returns the receiver to idle with no flag raised. The stored bytes and the count are kept. If `abort` falls in the same cycle as lead-out detection, the abort wins and `done_irq` stays low.
- R9: `arm` clears all flags, the count and the phase state, and starts in phase 1. If `arm` and `abort` are high in the same cycle, `arm` wins.
- R10: Read requests are refused while busy. An accepted request returns the byte at `rd_req_addr` one cycle later, with `rd_rsp_valid` high.
- R11: At most one of `done_irq`, `overflow` and `timeout` is high at a time. Each one stays high until the next `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| line_a_in | input | 1 | Bus line A (asynchronous) |
| line_b_in | input | 1 | Bus line B (asynchronous) |
| arm | input | 1 | Clear state and start receiving |
| abort | input | 1 | Stop receiving |
| timeout_cycles | input | TO_W | Idle cycles allowed before timeout |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request accepted (not busy) |
| rd_req_addr | input | AW | Byte address to read |
| rd_rsp_valid | output | 1 | Read data valid |
| rd_rsp_data | output | 8 | Read data |
| byte_count | output | CW | Number of complete bytes stored |
| busy | output | 1 | Receiver active |
| done_irq | output | 1 | Lead-out detected |
| overflow | output | 1 | Halted on full buffer |
| timeout | output | 1 | Halted on bus silence |

## Verification
The abort input and lead-out detection can fall in the same cycle. To provoke this, the bench drives A high while B is low at the end of phase 1. It then counts the two synchronizer stages and raises `abort` for exactly the cycle in which the phase logic would see the pattern. It judges the result by `done_irq` staying low and `busy` dropping.

`arm` and `abort` are also raised together. That case is judged by `busy` staying high.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_P1_WAIT,
    ST_P1_END,
    ST_P2_WAIT,
    ST_P2_END,
    ST_LEADOUT,
    ST_FULL,
    ST_TIMEDOUT
  } rx_state_t;

  function automatic logic state_active(rx_state_t s);
    return (s == ST_P1_WAIT) || (s == ST_P1_END) ||
           (s == ST_P2_WAIT) || (s == ST_P2_END);
  endfunction
endpackage

// File: rtl/acr_line_sync.sv
module acr_line_sync #(
  parameter int N_LINES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw_in,
  output logic [N_LINES-1:0] level,
  output logic [N_LINES-1:0] fall,
  output logic               any_edge
);
  logic [N_LINES-1:0] prev;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic meta, stable, last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= 1'b1;
        stable <= 1'b1;
        last   <= 1'b1;
      end else begin
        meta   <= raw_in[i];
        stable <= meta;
        last   <= stable;
      end
    end
    assign level[i] = stable;
    assign prev[i]  = last;
    assign fall[i]  = last & ~stable;
  end

  assign any_edge = |(level ^ prev);
endmodule

// File: rtl/acr_timeout.sv
module acr_timeout #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);
  logic [TO_W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       idle_cnt <= '0;
    else if (!run || restart)         idle_cnt <= '0;
    else if (idle_cnt != {TO_W{1'b1}}) idle_cnt <= idle_cnt + 1'b1;
  end

  assign expire = run && (idle_cnt >= limit);
endmodule

// File: rtl/acr_byte_store.sv
module acr_byte_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bit_valid,
  input  logic          bit_val,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [7:0] mem [DEPTH];
  logic [6:0] shreg;
  logic [2:0] nbits;
  logic       wr_en;

  assign full  = (count == CW'(DEPTH));
  assign wr_en = bit_valid && !clear && (nbits == 3'd7) && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      nbits <= '0;
      count <= '0;
    end else if (clear) begin
      shreg <= '0;
      nbits <= '0;
      count <= '0;
    end else if (bit_valid) begin
      shreg <= {shreg[5:0], bit_val};
      nbits <= nbits + 3'd1;
      if (wr_en) count <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[count[AW-1:0]] <= {shreg, bit_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < CW'(DEPTH))) else $error("write past buffer end"); // R6

  AST_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !wr_en) |=> $stable(count)) else $error("count moved"); // R3
endmodule

// File: rtl/acr_phase_fsm.sv
module acr_phase_fsm
  import acr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic abort,
  input  logic a_lvl,
  input  logic b_lvl,
  input  logic a_fall,
  input  logic b_fall,
  input  logic buf_full,
  input  logic expire,
  output logic bit_valid,
  output logic bit_val,
  output logic busy,
  output logic done,
  output logic ovf,
  output logic tmo
);
  rx_state_t st, nxt;

  always_comb begin
    nxt       = st;
    bit_valid = 1'b0;
    bit_val   = 1'b0;
    if (arm) begin
      nxt = ST_P1_WAIT;
    end else if (abort && state_active(st)) begin
      nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_P1_WAIT: begin
          if (a_fall) begin
            bit_valid = 1'b1;
            bit_val   = b_lvl;
            nxt       = ST_P1_END;
          end else if (expire) nxt = ST_TIMEDOUT;
        end
        ST_P1_END: begin
          if (a_lvl && !b_lvl) nxt = ST_LEADOUT;
          else if (b_lvl)      nxt = ST_P2_WAIT;
          else if (expire)     nxt = ST_TIMEDOUT;
        end
        ST_P2_WAIT: begin
          if (b_fall) begin
            bit_valid = 1'b1;
            bit_val   = a_lvl;
            nxt       = ST_P2_END;
          end else if (expire) nxt = ST_TIMEDOUT;
        end
        ST_P2_END: begin
          if (a_lvl)       nxt = buf_full ? ST_FULL : ST_P1_WAIT;
          else if (expire) nxt = ST_TIMEDOUT;
        end
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign busy = state_active(st);
  assign done = (st == ST_LEADOUT);
  assign ovf  = (st == ST_FULL);
  assign tmo  = (st == ST_TIMEDOUT);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, ovf, tmo})) else $error("flags overlap"); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done) else $error("done dropped"); // R11

  AST_LEADOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(a_lvl && !b_lvl && !abort)) else $error("bad lead-out"); // R5

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !arm && busy) |=> (!busy && !done && !ovf && !tmo)) else $error("abort ignored"); // R8

  AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> $past(expire)) else $error("timeout without expiry"); // R7
endmodule

// File: rtl/acr_rx.sv
module acr_rx #(
  parameter int DEPTH = 64,
  parameter int TO_W  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_a_in,
  input  logic            line_b_in,
  input  logic            arm,
  input  logic            abort,
  input  logic [TO_W-1:0] timeout_cycles,
  input  logic            rd_req_valid,
  output logic            rd_req_ready,
  input  logic [AW-1:0]   rd_req_addr,
  output logic            rd_rsp_valid,
  output logic [7:0]      rd_rsp_data,
  output logic [CW-1:0]   byte_count,
  output logic            busy,
  output logic            done_irq,
  output logic            overflow,
  output logic            timeout
);
  logic [1:0] lvl, fall;
  logic       any_edge, expire, bit_valid, bit_val, buf_full, rd_fire;

  acr_line_sync #(.N_LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in({line_b_in, line_a_in}),
    .level(lvl), .fall(fall), .any_edge(any_edge)
  );

  acr_timeout #(.TO_W(TO_W)) u_timeout (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(any_edge || arm),
    .limit(timeout_cycles), .expire(expire)
  );

  acr_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort),
    .a_lvl(lvl[0]), .b_lvl(lvl[1]), .a_fall(fall[0]), .b_fall(fall[1]),
    .buf_full(buf_full), .expire(expire),
    .bit_valid(bit_valid), .bit_val(bit_val),
    .busy(busy), .done(done_irq), .ovf(overflow), .tmo(timeout)
  );

  assign rd_req_ready = !busy;
  assign rd_fire      = rd_req_valid && rd_req_ready;

  acr_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(arm),
    .bit_valid(bit_valid), .bit_val(bit_val),
    .rd_en(rd_fire), .rd_addr(rd_req_addr), .rd_data(rd_rsp_data),
    .count(byte_count), .full(buf_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_rsp_valid <= 1'b0;
    else        rd_rsp_valid <= rd_fire;
  end

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |-> $past(rd_req_valid && !busy)) else $error("stray response"); // R10

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && busy) |=> !rd_rsp_valid) else $error("read while busy"); // R10
endmodule

// File: tb/acr_rx_bench.sv
module acr_rx_bench;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int H  = 4;

  logic clk = 0, rst_n = 0;
  logic line_a = 1, line_b = 1, arm = 0, abort = 0;
  logic [15:0] to_cyc = 16'd40;
  logic rd_req_valid = 0, rd_req_ready, rd_rsp_valid;
  logic [AW-1:0] rd_req_addr = '0;
  logic [7:0] rd_rsp_data;
  logic [CW-1:0] byte_count;
  logic busy, done_irq, overflow, timeout;

  int n_checks = 0, n_errors = 0;
  logic [7:0] exp_buf [DEPTH];

  always #10 clk = ~clk;

  acr_rx #(.DEPTH(DEPTH), .TO_W(16)) u_acr_rx (
    .clk(clk), .rst_n(rst_n), .line_a_in(line_a), .line_b_in(line_b),
    .arm(arm), .abort(abort), .timeout_cycles(to_cyc),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .byte_count(byte_count), .busy(busy), .done_irq(done_irq),
    .overflow(overflow), .timeout(timeout)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pack_status(logic b, logic d, logic o, logic t);
    return {28'd0, b, d, o, t};
  endfunction

  task automatic step();
    repeat (H) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic send_pair(logic b0, logic b1);
    line_b = b0; step();
    line_a = 0;  step();
    line_b = 1;  step();
    line_a = b1; step();
    line_b = 0;  step();
    line_a = 1;  step();
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i > 0; i -= 2) send_pair(v[i], v[i-1]);
  endtask

  task automatic lead_out();
    line_b = 0; step();
    line_a = 0; step();
    line_a = 1; step();
    line_b = 1; step();
  endtask

  task automatic read_byte(int addr, output logic [7:0] d, output logic v);
    @(negedge clk); rd_req_valid = 1; rd_req_addr = AW'(addr);
    @(negedge clk); rd_req_valid = 0; d = rd_rsp_data; v = rd_rsp_valid;
  endtask

  task automatic check_buffer(string req, int n);
    logic [7:0] d; logic v;
    for (int k = 0; k < n; k++) begin
      read_byte(k, d, v);
      check({req, " rsp_valid"}, int'(v), 1);
      check({req, " data"}, int'(d), int'(exp_buf[k]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v; int len; int unused;
    unused = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", pack_status(busy, done_irq, overflow, timeout), 0);
    check("R1 count", int'(byte_count), 0);
    check("R1 ready", int'(rd_req_ready), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R5 directed packet, mixed bit values
    do_arm();
    check("R9 busy after arm", int'(busy), 1);
    exp_buf[0] = 8'hA5; exp_buf[1] = 8'h3C;
    send_byte(8'hA5); send_byte(8'h3C);
    // R10 read refused while busy
    @(negedge clk); rd_req_valid = 1;
    check("R10 ready while busy", int'(rd_req_ready), 0);
    @(negedge clk); rd_req_valid = 0;
    check("R10 no response while busy", int'(rd_rsp_valid), 0);
    lead_out(); step();
    check("R5 status", pack_status(busy, done_irq, overflow, timeout), 4'b0100);
    check("R3 count", int'(byte_count), 2);
    check_buffer("R2 R3", 2);
    step();
    check("R11 done held", int'(done_irq), 1);

    // R3 R5 random packets
    for (int p = 0; p < 3; p++) begin
      len = 1 + int'($urandom % 10);
      do_arm();
      check("R9 flags cleared", pack_status(busy, done_irq, overflow, timeout), 4'b1000);
      for (int k = 0; k < len; k++) begin
        exp_buf[k] = 8'($urandom);
        send_byte(exp_buf[k]);
      end
      lead_out(); step();
      check("R5 random done", int'(done_irq), 1);
      check("R3 random count", int'(byte_count), len);
      check_buffer("R3 random", len);
    end

    // R4 partial final byte discarded
    do_arm();
    check("R9 count cleared", int'(byte_count), 0);
    exp_buf[0] = 8'h5A; exp_buf[1] = 8'hFF; exp_buf[2] = 8'h00;
    send_byte(8'h5A); send_byte(8'hFF); send_byte(8'h00);
    send_pair(1, 0); send_pair(1, 1);
    lead_out(); step();
    check("R4 count", int'(byte_count), 3);
    check("R4 done", int'(done_irq), 1);
    check_buffer("R4", 3);

    // R6 overflow and truncation
    do_arm();
    for (int k = 0; k < DEPTH + 2; k++) begin
      logic [7:0] bv = 8'($urandom);
      if (k < DEPTH) exp_buf[k] = bv;
      if (overflow) break;
      send_byte(bv);
    end
    step();
    check("R6 status", pack_status(busy, done_irq, overflow, timeout), 4'b0010);
    check("R6 count", int'(byte_count), DEPTH);
    read_byte(0, d, v);
    check("R6 first byte", int'(d), int'(exp_buf[0]));
    read_byte(DEPTH - 1, d, v);
    check("R6 last byte", int'(d), int'(exp_buf[DEPTH-1]));

    // R7 timeout mid-packet
    do_arm();
    send_byte(8'h81);
    line_b = 0; step();
    repeat (60) @(negedge clk);
    check("R7 status", pack_status(busy, done_irq, overflow, timeout), 4'b0001);
    check("R7 count kept", int'(byte_count), 1);
    line_b = 1; step();

    // R8 abort keeps data, no flag
    do_arm();
    exp_buf[0] = 8'hC3;
    send_byte(8'hC3);
    @(negedge clk); abort = 1; @(negedge clk); abort = 0;
    check("R8 abort status", pack_status(busy, done_irq, overflow, timeout), 0);
    check("R8 count kept", int'(byte_count), 1);
    check_buffer("R8", 1);
    line_b = 0; line_a = 0; step(); line_a = 1; step(); line_b = 1; step();
    check("R8 idle ignores lines", int'(done_irq), 0);

    // R8 abort collides with lead-out detection
    do_arm();
    send_byte(8'h42);
    line_b = 0; step();
    line_a = 0; step();
    @(negedge clk); line_a = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    step();
    check("R8 abort beats lead-out", pack_status(busy, done_irq, overflow, timeout), 0);
    line_b = 1; step();

    // R9 arm beats abort
    @(negedge clk); arm = 1; abort = 1;
    @(negedge clk); arm = 0; abort = 0;
    check("R9 arm wins", int'(busy), 1);
    @(negedge clk); abort = 1; @(negedge clk); abort = 0;

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule